// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block keeps the programmable configuration of a small logic device in registers and serves it through a single command port. It holds an 18-bit architecture control word (two global mode bits plus a mode bit and a polarity bit for each of eight output cells), a 64-bit user signature and a security bit. The logic-array pattern lives outside the block: the store reaches it through an address/data port with a write strobe and a whole-array clear strobe.

Commands (read, program, erase, lock) are taken on a valid/ready handshake. Once the lock is set, reads of the array or the control word return zeros and raise a denied flag, while the signature stays readable. The lock can only be cleared by a full erase, which wipes the control word, the signature, the lock and the array together and holds the port busy for a fixed number of cycles. Programming any word of a locked device runs that erase on its own and then writes the word.

Top module: `cfg_vault`

## Requirements
- R1: After reset the control word is zero, the lock is clear, `cmd_ready` is high and `rsp_valid` is low.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_op` encodes read as 0, program as 1, erase as 2, lock as 3; `cmd_space` selects the array as 0, the control word as 1, the signature as 2 and an unused space as 3. A read returns its data on `rsp_data` with `rsp_valid` high for one cycle, starting the cycle after acceptance; a program of an unlocked device takes effect at the accepting edge.
- R3: The control word is written from `cmd_wdata[17:0]` and read back zero-extended to 32 bits; bit 17 is the family-select bit, bit 16 the registers-allowed bit, bits 15:8 the per-cell polarity bits and bits 7:0 the per-cell mode bits, and `cfg_word` shows the stored word.
- R4: A lock command sets `cfg_locked`; while it is set, a read of the array or control-word space returns all zeros and `rsp_denied` is high for that one response cycle only.
- R5: Signature reads (address bit 0 selects the low half as 0 and the high half as 1) are never denied, locked or not.
- R6: An erase command clears the control word, both signature halves and the lock at the accepting edge, pulses `arr_clr` in the accepting cycle, and keeps `cmd_ready` low for exactly ERASE_CYCLES cycles after it.
- R7: A program command on a locked device performs the full erase of R6 (same busy time) and then stores its own word, so afterwards only that word is non-zero and the lock is clear.
- R8: Reads of the unused space return zero without denial, and programs to it change nothing.
- R9: While `cmd_ready` is low, a command held on `cmd_valid` is not taken and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Store can take a command |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 lock |
| cmd_space | input | 2 | 0 array, 1 control word, 2 signature, 3 unused |
| cmd_addr | input | 6 | Word index in the selected space |
| cmd_wdata | input | 32 | Program data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| rsp_denied | output | 1 | Read refused by the lock |
| arr_addr | output | 6 | Array word address |
| arr_wdata | output | 32 | Array write data |
| arr_we | output | 1 | Array write strobe |
| arr_clr | output | 1 | Whole-array clear strobe |
| arr_rdata | input | 32 | Array read data for `arr_addr` |
| cfg_word | output | 18 | Stored architecture control word |
| cfg_locked | output | 1 | Security bit |

## Verification
The two functions that meet in one command are the automatic erase and the deferred program write: a program issued on a locked device must clear everything and then land its own word at the end of the busy window. The bench locks a device holding a control word, a signature and an array word, programs one signature half, counts the busy cycles, and then reads every space to confirm that only the new half survived and the lock is clear. A second overlap is provoked by holding a program on the port during an erase and confirming afterwards that it was dropped.

// File: rtl/cfg_vault.sv
module cfg_vault #(
  parameter int ARR_AW       = 6,
  parameter int DATA_W       = 32,
  parameter int CW_W         = 18,
  parameter int SIG_W        = 64,
  parameter int ERASE_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_space,
  input  logic [ARR_AW-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_denied,
  output logic [ARR_AW-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_we,
  output logic              arr_clr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [CW_W-1:0]   cfg_word,
  output logic              cfg_locked
);
  localparam int SIG_WORDS = SIG_W / DATA_W;
  localparam int SIX_W     = (SIG_WORDS > 1) ? $clog2(SIG_WORDS) : 1;
  localparam int CNT_W     = $clog2(ERASE_CYCLES + 1);
  localparam logic [1:0] OP_RD = 2'd0, OP_PG = 2'd1, OP_ER = 2'd2, OP_LK = 2'd3;
  localparam logic [1:0] SP_ARR = 2'd0, SP_CW = 2'd1, SP_SIG = 2'd2;

  logic [CNT_W-1:0]  cnt_q;
  logic              lock_q;
  logic [CW_W-1:0]   cw_q;
  logic [DATA_W-1:0] sig_q [SIG_WORDS];
  logic              pend_q;
  logic [1:0]        pend_space;
  logic [ARR_AW-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  assign cmd_ready  = (cnt_q == '0);
  assign cfg_word   = cw_q;
  assign cfg_locked = lock_q;

  wire acc      = cmd_valid && cmd_ready;
  wire acc_rd   = acc && cmd_op == OP_RD;
  wire acc_pg   = acc && cmd_op == OP_PG;
  wire acc_lk   = acc && cmd_op == OP_LK;
  wire erase_go = (acc && cmd_op == OP_ER) || (acc_pg && lock_q);
  wire fin      = pend_q && cnt_q == CNT_W'(1);
  wire wr_en    = (acc_pg && !lock_q) || fin;

  wire [1:0]        wr_space = fin ? pend_space : cmd_space;
  wire [ARR_AW-1:0] wr_addr  = fin ? pend_addr  : cmd_addr;
  wire [DATA_W-1:0] wr_data  = fin ? pend_data  : cmd_wdata;
  wire [SIX_W-1:0]  wr_six   = wr_addr[SIX_W-1:0];
  wire [SIX_W-1:0]  rd_six   = cmd_addr[SIX_W-1:0];

  assign arr_addr  = wr_addr;
  assign arr_wdata = wr_data;
  assign arr_we    = wr_en && wr_space == SP_ARR;
  assign arr_clr   = erase_go;

  wire hidden = lock_q && (cmd_space == SP_ARR || cmd_space == SP_CW);

  logic [DATA_W-1:0] rd_val;
  always_comb begin
    case (cmd_space)
      SP_ARR:  rd_val = arr_rdata;
      SP_CW:   rd_val = DATA_W'(cw_q);
      SP_SIG:  rd_val = sig_q[rd_six];
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      lock_q     <= 1'b0;
      cw_q       <= '0;
      pend_q     <= 1'b0;
      pend_space <= '0;
      pend_addr  <= '0;
      pend_data  <= '0;
      rsp_valid  <= 1'b0;
      rsp_denied <= 1'b0;
      rsp_data   <= '0;
      for (int i = 0; i < SIG_WORDS; i++) sig_q[i] <= '0;
    end else begin
      rsp_valid  <= acc_rd;
      rsp_denied <= acc_rd && hidden;
      if (acc_rd) rsp_data <= hidden ? '0 : rd_val;
      if (erase_go) begin
        cw_q       <= '0;
        lock_q     <= 1'b0;
        cnt_q      <= CNT_W'(ERASE_CYCLES);
        pend_q     <= acc_pg;
        pend_space <= cmd_space;
        pend_addr  <= cmd_addr;
        pend_data  <= cmd_wdata;
        for (int i = 0; i < SIG_WORDS; i++) sig_q[i] <= '0;
      end else begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        if (fin) pend_q <= 1'b0;
        if (acc_lk) lock_q <= 1'b1;
        if (wr_en && wr_space == SP_CW) cw_q <= wr_data[CW_W-1:0];
        if (wr_en && wr_space == SP_SIG) sig_q[wr_six] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/cfg_vault_chk.sv
module cfg_vault_chk #(
  parameter int DATA_W = 32,
  parameter int CW_W   = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [1:0]        cmd_space,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_denied,
  input logic              arr_clr,
  input logic [CW_W-1:0]   cfg_word,
  input logic              cfg_locked
);
  wire acc = cmd_valid && cmd_ready;

  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc && cmd_op == 2'd0));

  assert_denied_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_denied |-> (rsp_valid && rsp_data == '0));

  assert_lock_by_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_locked) |-> $past(acc && cmd_op == 2'd3));

  assert_sig_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd0 && cmd_space == 2'd2) |=> (rsp_valid && !rsp_denied));

  assert_erase_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd2) |=> (cfg_word == '0 && !cfg_locked && !cmd_ready));

  assert_erase_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd2) |-> arr_clr);

  assert_locked_prog_erases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd1 && cfg_locked) |=> (!cfg_locked && !cmd_ready));

  assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> !arr_clr);
endmodule

bind cfg_vault cfg_vault_chk #(.DATA_W(DATA_W), .CW_W(CW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_space(cmd_space), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .rsp_denied(rsp_denied), .arr_clr(arr_clr),
  .cfg_word(cfg_word), .cfg_locked(cfg_locked)
);

// File: tb/cfg_vault_tb.sv
`timescale 1ns/1ps
module cfg_vault_tb;
  localparam int AW = 6, DW = 32, CWW = 18, ERC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0, cmd_space = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic rsp_valid, rsp_denied, arr_we, arr_clr, cfg_locked;
  logic [DW-1:0] rsp_data, arr_wdata, arr_rdata;
  logic [AW-1:0] arr_addr;
  logic [CWW-1:0] cfg_word;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  logic [DW-1:0] mem [2**AW];
  assign arr_rdata = mem[arr_addr];
  always_ff @(posedge clk) begin
    if (arr_clr) for (int i = 0; i < 2**AW; i++) mem[i] <= '0;
    else if (arr_we) mem[arr_addr] <= arr_wdata;
  end
  initial for (int i = 0; i < 2**AW; i++) mem[i] = '0;

  cfg_vault #(.ARR_AW(AW), .DATA_W(DW), .CW_W(CWW), .ERASE_CYCLES(ERC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_space(cmd_space), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_denied(rsp_denied),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_clr(arr_clr),
    .arr_rdata(arr_rdata), .cfg_word(cfg_word), .cfg_locked(cfg_locked));

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] sp, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_space = sp; cmd_addr = ad; cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_chk(input logic [1:0] sp, input logic [AW-1:0] ad, input logic [DW-1:0] exp, input bit den, input string req);
    issue(2'd0, sp, ad, '0);
    check(rsp_valid && rsp_data == exp && rsp_denied == den, req, rsp_data, exp);
  endtask

  // {op, space, addr, wdata, expected, denied, is_check}
  localparam int NV = 17;
  localparam logic [75:0] VEC [NV] = '{
    {2'd1, 2'd1, 6'd0, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0},
    {2'd0, 2'd1, 6'd0, 32'h0, 32'h0003_FFFF, 1'b0, 1'b1},
    {2'd1, 2'd2, 6'd0, 32'hA5A5_1234, 32'h0, 1'b0, 1'b0},
    {2'd1, 2'd2, 6'd1, 32'h0F0F_BEEF, 32'h0, 1'b0, 1'b0},
    {2'd0, 2'd2, 6'd0, 32'h0, 32'hA5A5_1234, 1'b0, 1'b1},
    {2'd0, 2'd2, 6'd1, 32'h0, 32'h0F0F_BEEF, 1'b0, 1'b1},
    {2'd1, 2'd0, 6'd5, 32'hDEAD_BEEF, 32'h0, 1'b0, 1'b0},
    {2'd0, 2'd0, 6'd5, 32'h0, 32'hDEAD_BEEF, 1'b0, 1'b1},
    {2'd0, 2'd0, 6'd6, 32'h0, 32'h0, 1'b0, 1'b1},
    {2'd1, 2'd3, 6'd0, 32'h1234_5678, 32'h0, 1'b0, 1'b0},
    {2'd0, 2'd3, 6'd0, 32'h0, 32'h0, 1'b0, 1'b1},
    {2'd1, 2'd1, 6'd0, 32'h0001_2A5C, 32'h0, 1'b0, 1'b0},
    {2'd0, 2'd1, 6'd0, 32'h0, 32'h0001_2A5C, 1'b0, 1'b1},
    {2'd3, 2'd0, 6'd0, 32'h0, 32'h0, 1'b0, 1'b0},
    {2'd0, 2'd1, 6'd0, 32'h0, 32'h0, 1'b1, 1'b1},
    {2'd0, 2'd0, 6'd5, 32'h0, 32'h0, 1'b1, 1'b1},
    {2'd0, 2'd2, 6'd1, 32'h0, 32'h0F0F_BEEF, 1'b0, 1'b1}
  };
  localparam string VREQ [NV] = '{"R2", "R3", "R2", "R2", "R5", "R5", "R2", "R2", "R2",
    "R8", "R8", "R3", "R3", "R4", "R4", "R4", "R5"};

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfg_word == '0 && !cfg_locked && cmd_ready && !rsp_valid, "R1", {14'b0, cfg_word}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_word == '0 && !cfg_locked && cmd_ready && !rsp_valid, "R1", {31'b0, cmd_ready}, 32'h1);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][75:74], VEC[v][73:72], VEC[v][71:66], VEC[v][65:34]);
      if (VEC[v][0])
        check(rsp_valid && rsp_data == VEC[v][33:2] && rsp_denied == VEC[v][1], VREQ[v], rsp_data, VEC[v][33:2]);
    end

    // R3: fields visible on cfg_word (bit16 registers-allowed set, bit17 family clear)
    check(cfg_word == 18'h12A5C && cfg_word[16] && !cfg_word[17], "R3", {14'b0, cfg_word}, 32'h12A5C);
    // R4: lock visible, denied pulse lasts one cycle
    check(cfg_locked, "R4", {31'b0, cfg_locked}, 32'h1);
    issue(2'd0, 2'd0, 6'd5, '0);
    @(negedge clk);
    check(!rsp_denied && !rsp_valid, "R4", {31'b0, rsp_denied}, 32'h0);

    // R7: program while locked -> automatic erase then write
    issue(2'd1, 2'd2, 6'd1, 32'h1111_2222);
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
    check(n == ERC, "R7", n, ERC);
    check(!cfg_locked && cfg_word == '0, "R7", {14'b0, cfg_word}, '0);
    read_chk(2'd2, 6'd1, 32'h1111_2222, 1'b0, "R7");
    read_chk(2'd2, 6'd0, 32'h0, 1'b0, "R7");
    read_chk(2'd1, 6'd0, 32'h0, 1'b0, "R7");
    read_chk(2'd0, 6'd5, 32'h0, 1'b0, "R7");

    // R6 and R9: erase clears everything, command held while busy is dropped
    issue(2'd1, 2'd1, 6'd0, 32'h0000_0003);
    issue(2'd1, 2'd0, 6'd7, 32'h0000_0077);
    issue(2'd3, 2'd0, 6'd0, '0);
    issue(2'd2, 2'd0, 6'd0, '0);
    check(cfg_word == '0 && !cfg_locked && !cmd_ready, "R6", {14'b0, cfg_word}, '0);
    cmd_op = 2'd1; cmd_space = 2'd1; cmd_addr = '0; cmd_wdata = 32'h0002_AAAA; cmd_valid = 1'b1;
    n = 0;
    while (!cmd_ready) begin
      n++;
      if (n == 3) cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(n == ERC, "R6", n, ERC);
    check(cfg_word == '0, "R9", {14'b0, cfg_word}, '0);
    read_chk(2'd1, 6'd0, 32'h0, 1'b0, "R9");
    read_chk(2'd0, 6'd7, 32'h0, 1'b0, "R6");
    read_chk(2'd2, 6'd1, 32'h0, 1'b0, "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule